// File: doc/BRIEF.md
# Dual Data Pointer Register Bank

This block holds two 16-bit pointers for addressing external data and code memory, plus a small auxiliary select register whose bit 0 decides which pointer is active. The processor core uses the active pointer for every pointer operation: loading a 16-bit constant, incrementing, and presenting an address for indexed code reads, external reads and writes, and indexed jumps. The inactive pointer is left untouched. Forming the address, running the bus cycle and adding the accumulator are handled outside this block.

Software reaches the pointers through one pair of special-function-register addresses. Address 82h is the low byte of whichever pointer is active, and 83h is its high byte. The select register sits at A2h. It stores only bits 0, 3 and 4, and every other bit reads as zero. Because of this, a read-add-one-write of the register toggles the selection and leaves bits 3 and 4 unchanged. All controls are single-cycle strobes with no handshake. The block never stalls, so there is no back-pressure, and each strobe takes effect at the next clock edge.

Top module: `dual_dptr_bank`

## Requirements
- R1: After reset, both pointers hold 0000h and the select register reads 00h, so `ptr_sel` is 0 and `ptr_addr` is 0000h.
- R2: Select bit 0 chooses the active pointer (0 selects pointer 0, 1 selects pointer 1). `ptr_addr` and `ptr_sel` reflect a new selection in the cycle after the write to A2h.
- R3: SFR reads are combinational. 82h returns the low byte of the active pointer, 83h returns its high byte, and A2h returns the select register. Any other address reads 00h with `sfr_hit` low.
- R4: An SFR write to 82h or 83h replaces only that byte of the active pointer.
- R5: `ptr_inc` adds one to the full 16-bit active pointer, and FFFFh wraps to 0000h.
- R6: `ptr_load` replaces the active pointer with `ptr_load_val`. When `ptr_load` and `ptr_inc` are both asserted, the load wins.
- R7: No load, increment or byte write ever changes the inactive pointer.
- R8: An SFR write to a byte of the active pointer in the same cycle as a load or increment wins. The load or increment is discarded.
- R9: A write to A2h stores bits 0, 3 and 4. Bits 1, 2, 5, 6 and 7 are discarded and always read as zero.
- R10: Reading A2h, adding one and writing the result back toggles bit 0 and keeps bits 3 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sfr_addr | input | 8 | SFR address for read and write |
| sfr_we | input | 1 | SFR write strobe |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | Combinational SFR read data |
| sfr_hit | output | 1 | High when sfr_addr is one of the three owned addresses |
| ptr_load | input | 1 | Load the active pointer with a constant |
| ptr_load_val | input | 16 | Constant for ptr_load |
| ptr_inc | input | 1 | Increment the active pointer |
| ptr_sel | output | 1 | Current select bit |
| ptr_addr | output | 16 | Active pointer value |

## Verification
Every strobe (SFR write, load, increment) shows its result one clock edge later, because each passes through exactly one register before reaching `ptr_addr`, `ptr_sel` or the read mux. The bench drives each strobe for exactly one rising edge and samples 1 ns after that edge, well before the next one. SFR reads have no latency. The bench sets the address away from any edge, waits 1 ns, and checks `sfr_rdata` within the same cycle. To show the right pointer was updated, each test switches the selection and compares the pointer that was inactive with the value it held before.

// File: rtl/dual_dptr_pkg.sv
package dual_dptr_pkg;

  // SFR target decoded from the address bus
  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_LO   = 2'd1,
    TGT_HI   = 2'd2,
    TGT_AUX  = 2'd3
  } sfr_tgt_e;

  // Stored bits of the auxiliary select register
  typedef struct packed {
    logic flag_b4;
    logic flag_b3;
    logic bank;
  } aux_state_t;

  // Bit positions within the auxiliary register byte
  localparam int unsigned AUX_BANK_POS = 0;
  localparam int unsigned AUX_B3_POS   = 3;
  localparam int unsigned AUX_B4_POS   = 4;

endpackage

// File: rtl/dptr_sfr_decode.sv
module dptr_sfr_decode
  import dual_dptr_pkg::*;
#(
  parameter int unsigned AW       = 8,
  parameter logic [7:0]  LO_ADDR  = 8'h82,
  parameter logic [7:0]  HI_ADDR  = 8'h83,
  parameter logic [7:0]  AUX_ADDR = 8'hA2
) (
  input  logic [AW-1:0] addr,
  output sfr_tgt_e      tgt
);

  always_comb begin
    if (addr == AW'(LO_ADDR))       tgt = TGT_LO;
    else if (addr == AW'(HI_ADDR))  tgt = TGT_HI;
    else if (addr == AW'(AUX_ADDR)) tgt = TGT_AUX;
    else                            tgt = TGT_NONE;
  end

endmodule

// File: rtl/dptr_sel_reg.sv
module dptr_sel_reg
  import dual_dptr_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output aux_state_t        aux,
  output logic [DATA_W-1:0] rdata
);

  aux_state_t aux_q;
  logic       unused_bits;

  // Only three bits are kept; the rest of the write byte is dropped
  assign unused_bits = ^{wdata[DATA_W-1:AUX_B4_POS+1], wdata[AUX_B3_POS-1:AUX_BANK_POS+1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aux_q <= '0;
    end else if (we) begin
      aux_q.bank    <= wdata[AUX_BANK_POS];
      aux_q.flag_b3 <= wdata[AUX_B3_POS];
      aux_q.flag_b4 <= wdata[AUX_B4_POS];
    end
  end

  always_comb begin
    rdata               = '0;
    rdata[AUX_BANK_POS] = aux_q.bank;
    rdata[AUX_B3_POS]   = aux_q.flag_b3;
    rdata[AUX_B4_POS]   = aux_q.flag_b4;
  end

  assign aux = aux_q;

  AST_SEL_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (aux_q.bank == $past(wdata[AUX_BANK_POS]))); // R9
  AST_FLAGS_FOLLOW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (aux_q.flag_b3 == $past(wdata[AUX_B3_POS])) && (aux_q.flag_b4 == $past(wdata[AUX_B4_POS]))); // R9
  AST_SEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(aux_q)); // R2

endmodule

// File: rtl/dptr_slot.sv
module dptr_slot #(
  parameter int unsigned PTR_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 active,
  input  logic                 wr_lo,
  input  logic                 wr_hi,
  input  logic [PTR_W/2-1:0]   wdata,
  input  logic                 load,
  input  logic [PTR_W-1:0]     load_val,
  input  logic                 inc,
  output logic [PTR_W-1:0]     q
);

  localparam int unsigned BYTE_W = PTR_W / 2;

  logic [PTR_W-1:0] q_r;
  logic [PTR_W-1:0] q_nxt;
  logic             sfr_touch;

  assign sfr_touch = wr_lo | wr_hi;

  // Priority: SFR byte write, then load, then increment
  always_comb begin
    q_nxt = q_r;
    if (active) begin
      if (sfr_touch) begin
        if (wr_lo) q_nxt[BYTE_W-1:0]     = wdata;
        if (wr_hi) q_nxt[PTR_W-1:BYTE_W] = wdata;
      end else if (load) begin
        q_nxt = load_val;
      end else if (inc) begin
        q_nxt = q_r + PTR_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_nxt;
  end

  assign q = q_r;

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> $stable(q_r)); // R7
  AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (active && inc && !load && !sfr_touch) |=> (q_r == $past(q_r) + PTR_W'(1))); // R5
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (active && load && !sfr_touch) |=> (q_r == $past(load_val))); // R6
  AST_LO_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (active && wr_lo) |=> (q_r[BYTE_W-1:0] == $past(wdata))); // R8
  AST_LO_KEEPS_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (active && wr_lo && !wr_hi) |=> (q_r[PTR_W-1:BYTE_W] == $past(q_r[PTR_W-1:BYTE_W]))); // R4
  AST_HI_KEEPS_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (active && wr_hi && !wr_lo) |=> (q_r[BYTE_W-1:0] == $past(q_r[BYTE_W-1:0]))); // R4

endmodule

// File: rtl/dual_dptr_bank.sv
module dual_dptr_bank
  import dual_dptr_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter logic [7:0]  LO_ADDR  = 8'h82,
  parameter logic [7:0]  HI_ADDR  = 8'h83,
  parameter logic [7:0]  AUX_ADDR = 8'hA2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [7:0]            sfr_addr,
  input  logic                  sfr_we,
  input  logic [DATA_W-1:0]     sfr_wdata,
  output logic [DATA_W-1:0]     sfr_rdata,
  output logic                  sfr_hit,
  input  logic                  ptr_load,
  input  logic [2*DATA_W-1:0]   ptr_load_val,
  input  logic                  ptr_inc,
  output logic                  ptr_sel,
  output logic [2*DATA_W-1:0]   ptr_addr
);

  localparam int unsigned PTR_W   = 2 * DATA_W;
  localparam int unsigned NUM_PTR = 2;

  sfr_tgt_e          tgt;
  aux_state_t        aux;
  logic [DATA_W-1:0] aux_rdata;
  logic              wr_lo;
  logic              wr_hi;
  logic              wr_aux;
  logic [PTR_W-1:0]  slot_q [NUM_PTR];
  logic [PTR_W-1:0]  act_q;

  dptr_sfr_decode #(
    .AW       (8),
    .LO_ADDR  (LO_ADDR),
    .HI_ADDR  (HI_ADDR),
    .AUX_ADDR (AUX_ADDR)
  ) u_dec (
    .addr (sfr_addr),
    .tgt  (tgt)
  );

  assign wr_lo  = sfr_we && (tgt == TGT_LO);
  assign wr_hi  = sfr_we && (tgt == TGT_HI);
  assign wr_aux = sfr_we && (tgt == TGT_AUX);

  dptr_sel_reg #(
    .DATA_W (DATA_W)
  ) u_sel (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_aux),
    .wdata (sfr_wdata),
    .aux   (aux),
    .rdata (aux_rdata)
  );

  for (genvar gi = 0; gi < NUM_PTR; gi++) begin : g_slot
    dptr_slot #(
      .PTR_W (PTR_W)
    ) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .active   (aux.bank == gi[0]),
      .wr_lo    (wr_lo),
      .wr_hi    (wr_hi),
      .wdata    (sfr_wdata),
      .load     (ptr_load),
      .load_val (ptr_load_val),
      .inc      (ptr_inc),
      .q        (slot_q[gi])
    );
  end

  assign act_q    = aux.bank ? slot_q[1] : slot_q[0];
  assign ptr_addr = act_q;
  assign ptr_sel  = aux.bank;

  always_comb begin
    unique case (tgt)
      TGT_LO:  sfr_rdata = act_q[DATA_W-1:0];
      TGT_HI:  sfr_rdata = act_q[PTR_W-1:DATA_W];
      TGT_AUX: sfr_rdata = aux_rdata;
      default: sfr_rdata = '0;
    endcase
  end

  assign sfr_hit = (tgt != TGT_NONE);

  AST_MISS_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !sfr_hit |-> (sfr_rdata == '0)); // R3
  AST_RSVD_AUX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt == TGT_AUX) |-> (sfr_rdata[2:1] == 2'b00) && (sfr_rdata[DATA_W-1:5] == '0)); // R9
  AST_SEL_SWITCH_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_aux && !ptr_load && !ptr_inc) |=> (ptr_sel == $past(sfr_wdata[0]))); // R2

endmodule

// File: tb/dual_dptr_bank_tb_top.sv
module dual_dptr_bank_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  sfr_addr;
  logic        sfr_we;
  logic [7:0]  sfr_wdata;
  logic [7:0]  sfr_rdata;
  logic        sfr_hit;
  logic        ptr_load;
  logic [15:0] ptr_load_val;
  logic        ptr_inc;
  logic        ptr_sel;
  logic [15:0] ptr_addr;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  dual_dptr_bank dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .sfr_addr     (sfr_addr),
    .sfr_we       (sfr_we),
    .sfr_wdata    (sfr_wdata),
    .sfr_rdata    (sfr_rdata),
    .sfr_hit      (sfr_hit),
    .ptr_load     (ptr_load),
    .ptr_load_val (ptr_load_val),
    .ptr_inc      (ptr_inc),
    .ptr_sel      (ptr_sel),
    .ptr_addr     (ptr_addr)
  );

  task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  // One clock edge with the given strobes; returns 1 ns after the edge
  task automatic step(bit ld, logic [15:0] ldv, bit inc, bit we, logic [7:0] a, logic [7:0] d);
    ptr_load = ld; ptr_load_val = ldv; ptr_inc = inc;
    sfr_we = we; sfr_addr = a; sfr_wdata = d;
    @(posedge clk);
    #1;
    ptr_load = 1'b0; ptr_inc = 1'b0; sfr_we = 1'b0;
  endtask

  task automatic sfr_read(logic [7:0] a, output logic [7:0] v);
    sfr_we = 1'b0; sfr_addr = a;
    #1;
    v = sfr_rdata;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R1 ptr_addr", ptr_addr, 16'h0000);
    check("R1 ptr_sel", {15'd0, ptr_sel}, 16'h0000);
    sfr_read(8'hA2, v); check("R1 aux", {8'd0, v}, 16'h0000);
    step(0, 0, 0, 1, 8'hA2, 8'h01);
    check("R1 ptr1 reset", ptr_addr, 16'h0000);
    step(0, 0, 0, 1, 8'hA2, 8'h00);
  endtask

  task automatic t_bytes();
    logic [7:0] v;
    step(0, 0, 0, 1, 8'h82, 8'h34);
    check("R4 lo only", ptr_addr, 16'h0034);
    step(0, 0, 0, 1, 8'h83, 8'h12);
    check("R4 hi only", ptr_addr, 16'h1234);
    sfr_read(8'h82, v); check("R3 read lo", {8'd0, v}, 16'h0034);
    sfr_read(8'h83, v); check("R3 read hi", {8'd0, v}, 16'h0012);
    step(0, 0, 0, 1, 8'hA2, 8'h01);
    check("R2 sel next cycle", {15'd0, ptr_sel}, 16'h0001);
    check("R7 ptr1 untouched", ptr_addr, 16'h0000);
    step(0, 0, 0, 1, 8'h83, 8'hAB);
    step(0, 0, 0, 1, 8'h82, 8'hCD);
    check("R4 ptr1 bytes", ptr_addr, 16'hABCD);
    step(0, 0, 0, 1, 8'hA2, 8'h00);
    check("R7 ptr0 kept", ptr_addr, 16'h1234);
  endtask

  task automatic t_inc();
    step(1, 16'hFFFE, 0, 0, 8'h00, 8'h00);
    check("R6 load", ptr_addr, 16'hFFFE);
    step(0, 0, 1, 0, 8'h00, 8'h00);
    check("R5 inc", ptr_addr, 16'hFFFF);
    step(0, 0, 1, 0, 8'h00, 8'h00);
    check("R5 wrap", ptr_addr, 16'h0000);
    step(0, 0, 0, 1, 8'hA2, 8'h01);
    check("R7 ptr1 after inc", ptr_addr, 16'hABCD);
    step(0, 0, 0, 1, 8'hA2, 8'h00);
  endtask

  task automatic t_load();
    step(1, 16'h5A5A, 1, 0, 8'h00, 8'h00);
    check("R6 load beats inc", ptr_addr, 16'h5A5A);
  endtask

  task automatic t_conflict();
    step(1, 16'h12FF, 0, 0, 8'h00, 8'h00);
    step(0, 0, 1, 1, 8'h82, 8'h55);
    check("R8 write beats inc", ptr_addr, 16'h1255);
    step(1, 16'hFFFF, 0, 1, 8'h83, 8'h77);
    check("R8 write beats load", ptr_addr, 16'h7755);
    step(0, 0, 0, 1, 8'hA2, 8'h01);
    check("R7 ptr1 after conflicts", ptr_addr, 16'hABCD);
    step(0, 0, 0, 1, 8'hA2, 8'h00);
  endtask

  task automatic t_selreg();
    logic [7:0] v;
    step(0, 0, 0, 1, 8'hA2, 8'hFF);
    sfr_read(8'hA2, v); check("R9 stored bits", {8'd0, v}, 16'h0019);
    check("R9 sel set", ptr_addr, 16'hABCD);
    step(0, 0, 0, 1, 8'hA2, v + 8'd1);
    sfr_read(8'hA2, v); check("R10 toggle to 0", {8'd0, v}, 16'h0018);
    check("R10 ptr0 active", ptr_addr, 16'h7755);
    step(0, 0, 0, 1, 8'hA2, v + 8'd1);
    sfr_read(8'hA2, v); check("R10 toggle to 1", {8'd0, v}, 16'h0019);
    check("R10 ptr1 active", ptr_addr, 16'hABCD);
    sfr_read(8'h90, v);
    check("R3 miss data", {8'd0, v}, 16'h0000);
    check("R3 miss hit", {15'd0, sfr_hit}, 16'h0000);
  endtask

  initial begin
    #(10 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    sfr_addr = '0; sfr_we = 1'b0; sfr_wdata = '0;
    ptr_load = 1'b0; ptr_load_val = '0; ptr_inc = 1'b0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    t_reset();
    t_bytes();
    t_inc();
    t_load();
    t_conflict();
    t_selreg();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule